// File: doc/BRIEF.md
# Iterative NLFSR Hash Compression Core

This block compresses one 512-bit message block into a 32-bit-word hash state. The state is held in three register banks: a 12-word bank A, a 16-word bank B and a 16-word bank C. A 64-bit block counter sits beside them. A block of 16 words is taken through a valid/ready handshake. In the same clock edge that accepts it, the core runs a whole-block pre-processing pass.

The core then runs a 48-step keyed nonlinear-feedback permutation. Each step writes one new word into A and one into B, and both banks are shift registers that take the new word at their top end. One final clock edge adds folded C words into A, subtracts the message from C, and swaps B and C. The whole state is visible on read-only output buses at all times. Setting the initial value, padding and finalization are left to the surrounding logic, which simply feeds blocks one after another.

Word k of every bus occupies bits [32k+31:32k]. All arithmetic wraps modulo 2^32.

Top module: `nlfsr_hash_core`

## Requirements
- R1: After synchronous reset, state_a, state_b and state_c are all zero, state_w equals the parameter W_INIT, in_ready is 1 and done is 0.
- R2: in_ready is 1 only while the core is idle. A block is taken on a rising edge where in_valid and in_ready are both 1. While the core is busy, in_valid and in_block have no effect on the state.
- R3: On the accepting edge each B word becomes rotl17(B[k] + M[k]). A word 0 is XORed with the low 32 bits of the counter, and A word 1 with the high 32 bits, using the counter value from before the increment.
- R4: The counter increments by exactly one on every accepting edge and holds otherwise. A carry out of the low 32-bit half increments the high half.
- R5: The permutation runs 48 steps, t = 0..47, with i = t mod 16, p = t mod 12 and q = (t+11) mod 12. Each step computes A[p] = 3*(A[p] ^ 5*rotl15(A[q]) ^ C[(8-i) mod 16]) ^ B[(i+13) mod 16] ^ (B[(i+9) mod 16] & ~B[(i+6) mod 16]) ^ M[i]. It then computes B[i] = ~rotl1(B[i]) ^ (the new A[p]).
- R6: In post-processing each A[j] (j = 0..11) receives C[(j+3) mod 16] + C[(j+15) mod 16] + C[(j+11) mod 16].
- R7: In the same post-processing edge the new B is C[k] - M[k] for every word k, and the new C is the B value left by the permutation.
- R8: done is high for exactly one cycle. It goes high right after the 50th rising edge, counting the accepting edge as the first, and in_ready is 1 in that same cycle.
- R9: Blocks fed back to back chain through the state, and the counter carries across its 32-bit halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A message block is offered |
| in_ready | output | 1 | The core is idle and can take a block |
| in_block | input | 512 | Message block, word k at bits [32k+31:32k] |
| done | output | 1 | One-cycle pulse when a block's compression is complete |
| state_a | output | 384 | A bank, 12 words |
| state_b | output | 512 | B bank, 16 words |
| state_c | output | 512 | C bank, 16 words |
| state_w | output | 64 | Block counter |

## Verification
The assertions assume that reset is held for at least one rising edge before any block is offered. They also assume that the counter never wraps past its full 64-bit range within a run. The stimulus meets both conditions: it starts the counter two below the 32-bit carry point, so the carry into the high half is exercised within a handful of blocks. While a block is being processed, the bench keeps in_valid high and drives fresh random data, so the busy-time inputs are a live distraction for the state-hold checks and not a quiet bus.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int WORD_W   = 32;
    localparam int A_WORDS  = 12;
    localparam int B_WORDS  = 16;
    localparam int STEPS    = 48;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int FOLD     = 3;
    localparam int FOLD_OFS = 3;
    localparam int ROT_PRE  = 17;
    localparam int ROT_A    = 15;
    localparam int ROT_B    = 1;
    localparam int C_TAP    = 8;
    localparam int BX_TAP   = 13;
    localparam int BY_TAP   = 9;
    localparam int BZ_TAP   = 6;
    localparam int BLK_W    = B_WORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [A_WORDS-1:0] a_vec_t;
    typedef word_t [B_WORDS-1:0] b_vec_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PERM,
        PH_POST
    } phase_t;

    typedef struct packed {
        word_t a_cur;
        word_t a_prev;
        word_t c_tap;
        word_t b_cur;
        word_t b_x;
        word_t b_y;
        word_t b_z;
        word_t m_cur;
    } step_taps_t;

    function automatic word_t rotl(word_t x, int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t times3(word_t x);
        return x + (x << 1);
    endfunction

    function automatic word_t times5(word_t x);
        return x + (x << 2);
    endfunction
endpackage

// File: rtl/hc_counter.sv
module hc_counter #(
    parameter int HALF_W = 32,
    parameter logic [2*HALF_W-1:0] INIT = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc,
    output logic [2*HALF_W-1:0] cnt
);
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= INIT[HALF_W-1:0];
            hi_q <= INIT[2*HALF_W-1:HALF_W];
        end else if (inc) begin
            lo_q <= lo_q + 1'b1;
            if (&lo_q) begin
                hi_q <= hi_q + 1'b1;
            end
        end
    end

    assign cnt = {hi_q, lo_q};

    AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
        inc |=> cnt == $past(cnt) + 1'b1); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt)); // R4
endmodule

// File: rtl/hc_step.sv
module hc_step
    import hc_pkg::*;
(
    input  step_taps_t taps,
    output word_t      a_new,
    output word_t      b_new
);
    word_t a_mix;
    word_t b_gate;

    always_comb begin
        a_mix  = taps.a_cur ^ times5(rotl(taps.a_prev, ROT_A)) ^ taps.c_tap;
        b_gate = taps.b_y & (taps.b_z ^ {WORD_W{1'b1}});
        a_new  = times3(a_mix) ^ taps.b_x ^ b_gate ^ taps.m_cur;
        b_new  = (rotl(taps.b_cur, ROT_B) ^ {WORD_W{1'b1}}) ^ a_new;
    end
endmodule

// File: rtl/hc_post.sv
module hc_post
    import hc_pkg::*;
(
    input  a_vec_t a_in,
    input  b_vec_t c_in,
    output a_vec_t a_out
);
    for (genvar j = 0; j < A_WORDS; j++) begin : g_word
        word_t part [FOLD+1];
        assign part[0] = a_in[j];
        for (genvar k = 0; k < FOLD; k++) begin : g_fold
            assign part[k+1] = part[k] + c_in[(j + FOLD_OFS + A_WORDS*k) % B_WORDS];
        end
        assign a_out[j] = part[FOLD];
    end
endmodule

// File: rtl/nlfsr_hash_core.sv
module nlfsr_hash_core
    import hc_pkg::*;
#(
    parameter logic [2*WORD_W-1:0] W_INIT = 64'd1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [BLK_W-1:0]            in_block,
    output logic                        done,
    output logic [A_WORDS*WORD_W-1:0]   state_a,
    output logic [B_WORDS*WORD_W-1:0]   state_b,
    output logic [B_WORDS*WORD_W-1:0]   state_c,
    output logic [2*WORD_W-1:0]         state_w
);
    phase_t              phase_q;
    logic [STEP_W-1:0]   step_q;
    a_vec_t              a_q;
    b_vec_t              b_q;
    b_vec_t              c_q;
    b_vec_t              m_q;
    logic                done_q;
    logic                accept;
    logic [2*WORD_W-1:0] w_cnt;

    b_vec_t     blk;
    b_vec_t     b_pre;
    a_vec_t     a_pre;
    a_vec_t     a_post;
    b_vec_t     c_less_m;
    step_taps_t taps;
    word_t      a_new;
    word_t      b_new;

    assign blk    = in_block;
    assign accept = in_valid && (phase_q == PH_IDLE);

    hc_counter #(
        .HALF_W (WORD_W),
        .INIT   (W_INIT)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (accept),
        .cnt (w_cnt)
    );

    for (genvar k = 0; k < B_WORDS; k++) begin : g_pre
        assign b_pre[k]    = rotl(b_q[k] + blk[k], ROT_PRE);
        assign c_less_m[k] = c_q[k] - m_q[k];
    end

    for (genvar k = 0; k < A_WORDS; k++) begin : g_apre
        if (k == 0) begin : g_lo
            assign a_pre[k] = a_q[k] ^ w_cnt[WORD_W-1:0];
        end else if (k == 1) begin : g_hi
            assign a_pre[k] = a_q[k] ^ w_cnt[2*WORD_W-1:WORD_W];
        end else begin : g_pass
            assign a_pre[k] = a_q[k];
        end
    end

    always_comb begin
        taps.a_cur  = a_q[0];
        taps.a_prev = a_q[A_WORDS-1];
        taps.c_tap  = c_q[C_TAP];
        taps.b_cur  = b_q[0];
        taps.b_x    = b_q[BX_TAP];
        taps.b_y    = b_q[BY_TAP];
        taps.b_z    = b_q[BZ_TAP];
        taps.m_cur  = m_q[0];
    end

    hc_step u_step (
        .taps  (taps),
        .a_new (a_new),
        .b_new (b_new)
    );

    hc_post u_post (
        .a_in  (a_q),
        .c_in  (c_q),
        .a_out (a_post)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            a_q     <= '0;
            b_q     <= '0;
            c_q     <= '0;
            m_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        a_q     <= a_pre;
                        b_q     <= b_pre;
                        m_q     <= blk;
                        step_q  <= '0;
                        phase_q <= PH_PERM;
                    end
                end
                PH_PERM: begin
                    a_q    <= {a_new, a_q[A_WORDS-1:1]};
                    b_q    <= {b_new, b_q[B_WORDS-1:1]};
                    c_q    <= {c_q[B_WORDS-2:0], c_q[B_WORDS-1]};
                    m_q    <= {m_q[0], m_q[B_WORDS-1:1]};
                    step_q <= step_q + 1'b1;
                    if (step_q == STEP_W'(STEPS - 1)) begin
                        phase_q <= PH_POST;
                    end
                end
                PH_POST: begin
                    a_q     <= a_post;
                    b_q     <= c_less_m;
                    c_q     <= b_q;
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign in_ready = (phase_q == PH_IDLE);
    assign done     = done_q;
    assign state_a  = a_q;
    assign state_b  = b_q;
    assign state_c  = c_q;
    assign state_w  = w_cnt;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> ($stable(state_a) && $stable(state_b) && $stable(state_c))); // R2
    AST_BUSY_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(state_w)); // R4
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PERM) |-> (step_q < STEP_W'(STEPS))); // R5
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> in_ready); // R8
endmodule

// File: tb/tb_nlfsr_hash_core.sv
module tb_nlfsr_hash_core;
    localparam logic [63:0] W0 = 64'h0000_0000_FFFF_FFFE;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] in_block = '0;
    logic         in_ready;
    logic         done;
    logic [383:0] state_a;
    logic [511:0] state_b;
    logic [511:0] state_c;
    logic [63:0]  state_w;

    nlfsr_hash_core #(.W_INIT(W0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .done(done), .state_a(state_a),
        .state_b(state_b), .state_c(state_c), .state_w(state_w)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [31:0] ma [12];
    logic [31:0] mb [16];
    logic [31:0] mc [16];
    logic [63:0] mw;
    logic [31:0] msg [16];

    function automatic logic [31:0] r_rotl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [511:0] pack_a();
        logic [511:0] v = '0;
        for (int k = 0; k < 12; k++) v[32*k +: 32] = ma[k];
        return v;
    endfunction

    function automatic logic [511:0] pack_b();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[32*k +: 32] = mb[k];
        return v;
    endfunction

    function automatic logic [511:0] pack_c();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[32*k +: 32] = mc[k];
        return v;
    endfunction

    task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_sim();
        end
    end

    // R3 / R4 reference: pre-processing and counter step
    task automatic model_pre();
        for (int k = 0; k < 16; k++) mb[k] = r_rotl(mb[k] + msg[k], 17);
        ma[0] = ma[0] ^ mw[31:0];
        ma[1] = ma[1] ^ mw[63:32];
        mw = mw + 64'd1;
    endtask

    // R5, R6, R7 reference: permutation, fold-add, subtract and swap
    task automatic model_rest();
        logic [31:0] t;
        for (int j = 0; j < 3; j++) begin
            for (int i = 0; i < 16; i++) begin
                int p = (i + 16*j) % 12;
                int q = (i + 16*j + 11) % 12;
                t = ma[p] ^ (r_rotl(ma[q], 15) * 32'd5) ^ mc[(8 - i + 16) % 16];
                ma[p] = (t * 32'd3) ^ mb[(i+13)%16] ^ (mb[(i+9)%16] & ~mb[(i+6)%16]) ^ msg[i];
                mb[i] = ~r_rotl(mb[i], 1) ^ ma[p];
            end
        end
        for (int k = 0; k < 36; k++) ma[k%12] = ma[k%12] + mc[(k+3)%16];
        for (int k = 0; k < 16; k++) begin
            t = mc[k] - msg[k];
            mc[k] = mb[k];
            mb[k] = t;
        end
    endtask

    task automatic run_block(string tag);
        int n;
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 16; k++) in_block[32*k +: 32] = msg[k];
        while (!in_ready) @(negedge clk);
        model_pre();
        @(negedge clk);
        chk("R3", {tag, " B after pre"}, state_b, pack_b());
        chk("R3", {tag, " A after pre"}, state_a, pack_a());
        chk("R4", {tag, " counter after accept"}, {448'd0, state_w}, {448'd0, mw});
        chk("R2", {tag, " ready low while busy"}, {511'd0, in_ready}, 512'd0);
        for (int k = 0; k < 16; k++) in_block[32*k +: 32] = $urandom;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            for (int k = 0; k < 16; k++) in_block[32*k +: 32] = $urandom;
        end
        in_valid = 1'b0;
        model_rest();
        chk("R8", {tag, " done latency"}, 512'(n), 512'd50);
        chk("R8", {tag, " ready with done"}, {511'd0, in_ready}, 512'd1);
        chk("R5/R6", {tag, " A after block"}, state_a, pack_a());
        chk("R7", {tag, " B after block"}, state_b, pack_b());
        chk("R7", {tag, " C after block"}, state_c, pack_c());
        chk("R2", {tag, " counter unchanged by busy valid"}, {448'd0, state_w}, {448'd0, mw});
        @(negedge clk);
        chk("R8", {tag, " done one cycle"}, {511'd0, done}, 512'd0);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED);
        for (int k = 0; k < 12; k++) ma[k] = '0;
        for (int k = 0; k < 16; k++) begin mb[k] = '0; mc[k] = '0; end
        mw = W0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "A reset", state_a, 512'd0);
        chk("R1", "B reset", state_b, 512'd0);
        chk("R1", "C reset", state_c, 512'd0);
        chk("R1", "W reset", {448'd0, state_w}, {448'd0, W0});
        chk("R1", "ready/done reset", {510'd0, in_ready, done}, 512'd2);

        // R2: idle and no valid -> state holds
        repeat (4) @(negedge clk);
        chk("R2", "idle hold B", state_b, 512'd0);

        // directed: all-zero message from zero state
        for (int k = 0; k < 16; k++) msg[k] = '0;
        run_block("zero");
        // directed: all-ones message, counter carries into high half (R9)
        for (int k = 0; k < 16; k++) msg[k] = 32'hFFFF_FFFF;
        run_block("ones");
        // R9: carry reached
        chk("R9", "counter high half after carry", {448'd0, state_w}, {448'd0, 64'h0000_0001_0000_0000});
        // random chained blocks
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 16; k++) msg[k] = $urandom;
            run_block("random R9");
        end
        // R9: walking-one message
        for (int k = 0; k < 16; k++) msg[k] = 32'h1 << k;
        run_block("walk");
        finish_sim();
    end
endmodule